// File: doc/BRIEF.md
# Scroll Start-Line Counter

This block produces the pixel-memory row address for each display line being scanned. A host command writes a 7-bit start line. Moving the picture up or down, or switching to another page, then needs only a new start line and no rewrite of the pixel memory. A frame-start pulse copies the start line into a line counter. Each line-clock pulse then advances the counter by one. The counter value selects which memory row is fetched into the display latch for the current line.

Two geometries are supported. In mode 0 the scrollable area has 128 rows, each fetch moves 128 bits, and any start value is accepted. In mode 1 the area has 100 rows. A write of 100 to 127 is discarded in mode 1, and the earlier start value stays in force. A separate icon row lives at a fixed place in memory and never scrolls. When icons are enabled, the block raises an icon flag for one line slot after the last scrollable line of the frame. The fetch logic then reads the icon row instead of using the line address.

Top module: `scroll_line_ctr`

## Requirements
- R1: After reset, line_addr is 0 and icon_line is 0. The stored start line is 0, so the first frame_start yields line_addr 0.
- R2: In mode 0 (mode=0), a start_wr pulse stores any start_data value from 0 to 127.
- R3: In mode 1 (mode=1), a start_wr pulse with start_data from 100 to 127 is discarded, and the start line keeps its previous value. Values 0 to 99 are stored.
- R4: A frame_start pulse loads the stored start line into the counter, and line_addr shows it one cycle later.
- R5: Each line_clk pulse (without frame_start) raises line_addr by one. With neither pulse present, line_addr holds its value.
- R6: In mode 0 the counter wraps from 127 to 0.
- R7: In mode 1 the counter wraps from 99 to 0.
- R8: A start_wr in mid-frame does not alter the current scan. The new value is used from the next frame_start.
- R9: With icon_en=1, icon_line is 1 for exactly one line period per frame. That period starts after the line_clk that follows the last scrollable line, which is line clock number 128 (mode 0) or 100 (mode 1) after frame_start. The next line_clk or frame_start ends it. With icon_en=0, icon_line stays 0.
- R10: When frame_start and line_clk arrive in the same cycle, frame_start wins. The counter loads the start line and is not advanced.
- R11: When start_wr and frame_start arrive in the same cycle, the frame loads the start line stored before that write. The written value is used from the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Geometry select: 0 = 128 rows, 1 = 100 rows |
| start_wr | input | 1 | Start-line write strobe |
| start_data | input | 7 | Start-line value to write |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| line_clk | input | 1 | One-cycle pulse per scanned line |
| icon_en | input | 1 | Enables the icon line slot |
| line_addr | output | 7 | Memory row address for the current line |
| icon_line | output | 1 | High while the icon row is being fetched |

## Verification
A zero start line with a full frame checks the basic count and the icon slot. It also shows whether the slot falls after line clock 128, or after line clock 100 in the other mode. Start values just below the wrap point separate the mode 0 wrap at 127 from the mode 1 wrap at 99. Writes of exactly 100 and of 110 in mode 1, next to an accepted 95, show where the range gate lies. Writes made in mid-frame and in the same cycle as frame_start, and a frame_start coinciding with a line clock, show whether the load happens at the frame boundary and which pulse takes priority.

// File: rtl/scroll_line_ctr.sv
module scroll_line_ctr #(
  parameter int AW      = 7,
  parameter int ROWS_M0 = 128,
  parameter int ROWS_M1 = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          start_wr,
  input  logic [AW-1:0] start_data,
  input  logic          frame_start,
  input  logic          line_clk,
  input  logic          icon_en,
  output logic [AW-1:0] line_addr,
  output logic          icon_line
);
  localparam int IW = $clog2(ROWS_M0 + 2) + 1;
  localparam logic [IW-1:0] IDLE = '1;

  logic [AW-1:0] start_q;
  logic [AW-1:0] ctr_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] rows;
  logic          wr_ok;
  logic          at_last;

  assign rows    = mode ? IW'(ROWS_M1) : IW'(ROWS_M0);
  assign wr_ok   = !mode || (IW'(start_data) < IW'(ROWS_M1));
  assign at_last = IW'(ctr_q) >= rows - IW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= '0;
    else if (start_wr && wr_ok) start_q <= start_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctr_q <= '0;
    else if (frame_start) ctr_q <= start_q;
    else if (line_clk) ctr_q <= at_last ? '0 : ctr_q + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= IDLE;
    else if (frame_start) idx_q <= '0;
    else if (line_clk && idx_q <= rows) idx_q <= idx_q + IW'(1);
  end

  assign line_addr = ctr_q;
  assign icon_line = icon_en && (idx_q == rows);

  p_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && mode && start_data >= AW'(ROWS_M1)) |=> $stable(start_q));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (line_addr == $past(start_q)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_clk) |=> $stable(line_addr));
  p_wrap0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && line_clk && !frame_start && line_addr == AW'(ROWS_M0 - 1)) |=> (line_addr == '0));
  p_wrap1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && line_clk && !frame_start && line_addr == AW'(ROWS_M1 - 1)) |=> (line_addr == '0));
  p_icon_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    icon_line |-> icon_en);
  p_icon_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (icon_line && (line_clk || frame_start)) |=> !icon_line);
endmodule

// File: tb/scroll_line_ctr_bench.sv
module scroll_line_ctr_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       mode = 0, start_wr = 0, frame_start = 0, line_clk = 0, icon_en = 0;
  logic [6:0] start_data = 0;
  logic [6:0] line_addr;
  logic       icon_line;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  int m_start = 0, m_ctr = 0, m_idx = 255;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  scroll_line_ctr u_scroll_line_ctr (
    .clk(clk), .rst_n(rst_n), .mode(mode), .start_wr(start_wr),
    .start_data(start_data), .frame_start(frame_start), .line_clk(line_clk),
    .icon_en(icon_en), .line_addr(line_addr), .icon_line(icon_line));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr/icon actual=%0d/%0d expected=%0d/%0d", tag, act[7:1], act[0], exp[7:1], exp[0]);
    end
  endtask

  task automatic step(input bit fs, input bit lc, input bit wr, input int d, input string tag);
    int rows;
    @(negedge clk);
    frame_start = fs; line_clk = lc; start_wr = wr; start_data = 7'(d);
    rows = mode ? 100 : 128;
    if (fs) begin m_ctr = m_start; m_idx = 0; end
    else if (lc) begin
      m_ctr = (m_ctr >= rows - 1) ? 0 : m_ctr + 1;
      if (m_idx <= rows) m_idx++;
    end
    if (wr && (!mode || d < 100)) m_start = d;
    q_exp.push_back({7'(m_ctr), (icon_en && m_idx == rows)});
    q_tag.push_back(tag);
  endtask

  always begin
    @(posedge clk); #1;
    if (q_exp.size() > 0) check({line_addr, icon_line}, q_exp.pop_front(), q_tag.pop_front());
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({line_addr, icon_line}, 8'd0, "R1 reset");
    rst_n = 1;
    step(1, 0, 0, 0, "R1 first frame");
    repeat (3) step(0, 1, 0, 0, "R5 advance");
    repeat (2) step(0, 0, 0, 0, "R5 hold");
    step(0, 0, 1, 5, "R2 write 5");
    step(1, 0, 0, 0, "R4 load 5");
    repeat (2) step(0, 1, 0, 0, "R5 advance");
    step(0, 0, 1, 120, "R2 write 120");
    step(1, 0, 0, 0, "R4 load 120");
    repeat (10) step(0, 1, 0, 0, "R6 wrap 127");
    step(0, 0, 1, 0, "R2 write 0");
    icon_en = 1;
    step(1, 0, 0, 0, "R4 load 0");
    repeat (127) step(0, 1, 0, 0, "R9 scan m0");
    step(0, 1, 0, 0, "R9 icon slot m0");
    step(0, 0, 0, 0, "R9 icon held");
    repeat (2) step(0, 1, 0, 0, "R9 icon ends");
    mode = 1;
    step(0, 0, 1, 95, "R3 write 95");
    step(0, 0, 1, 100, "R3 write 100 ignored");
    step(0, 0, 1, 110, "R3 write 110 ignored");
    step(1, 0, 0, 0, "R3 load keeps 95");
    repeat (8) step(0, 1, 0, 0, "R7 wrap 99");
    step(0, 0, 1, 0, "R3 write 0");
    step(1, 0, 0, 0, "R4 load 0 m1");
    repeat (99) step(0, 1, 0, 0, "R9 scan m1");
    step(0, 1, 0, 0, "R9 icon slot m1");
    step(1, 0, 0, 0, "R9 icon ends at frame");
    step(0, 0, 1, 40, "R8 mid write");
    repeat (3) step(0, 1, 0, 0, "R8 scan unchanged");
    step(1, 0, 0, 0, "R8 next frame 40");
    step(0, 1, 0, 0, "R8 advance");
    step(1, 1, 0, 0, "R10 frame wins");
    step(1, 0, 1, 60, "R11 same-cycle write");
    step(0, 1, 0, 0, "R11 advance");
    step(1, 0, 0, 0, "R11 next frame 60");
    icon_en = 0;
    repeat (101) step(0, 1, 0, 0, "R9 icon disabled");
    step(0, 0, 0, 0, "R5 hold end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule